// File: doc/BRIEF.md
# Interrupt Register Bank Sequencer

When an interrupt is taken, this block copies the CPU's twenty working and special registers into a private bank. The copy runs in five steps of four registers each, and it finishes before the service routine's first instruction fetch is let through. While the copy runs, the block holds off that fetch with a stall output. The copy overlaps the other exception-entry work (vector read, status and return-address stacking), and that other work is handled elsewhere.

At the end of the service routine, software asks for the bank to be written back with a separate restore request. Restore writes the same five groups into the register file, again one group per cycle. Return from exception must wait until the restore has finished, which the block signals with a low busy and a one-cycle done pulse. A valid bit records whether the bank holds a save that has not yet been restored.

Top module: `irq_bank_seq`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `done`, `bank_valid`, `restore_err`, `fetch_stall` and `rf_wr_en` are all low.
- R2: A `save_trig` sampled while idle starts a save of five cycles, one group per cycle. Register slots are numbered 0–14 for R0–R14, 15 for MACH, 16 for MACL, 17 for GBR, 18 for PR and 19 for the vector base offset. Lane 0 sits in the low bits of `rf_rd_idx`. The groups are read in this order: {19,18,17,16}, {12,13,14,15}, {8,9,10,11}, {4,5,6,7}, {0,1,2,3}.
- R3: `fetch_stall` is high combinationally in the cycle in which an accepted `save_trig` is present. It stays high through all five save cycles and is low in the cycle after the last group is captured.
- R4: `busy` is high for exactly five cycles per save. In the cycle after the fifth, `busy` is low, `done` is high for one cycle and `bank_valid` is high.
- R5: A `rest_req` sampled while idle with `bank_valid` high drives `rf_wr_en` for five cycles. These cycles write the groups in the R2 order with the values captured by the save. Afterwards, `done` pulses for one cycle and `bank_valid` is cleared.
- R6: A `save_trig` or `rest_req` sampled while `busy` is high is ignored. The running sequence keeps its length and its order, and no second sequence follows it.
- R7: A `rest_req` sampled while idle with `bank_valid` low raises `restore_err` for exactly one cycle. It causes no register write and does not raise `busy`.
- R8: When `save_trig` and `rest_req` are sampled together while idle, the save runs and the restore request is dropped.
- R9: A save while `bank_valid` is already high replaces the bank contents, and `bank_valid` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| save_trig | input | 1 | Interrupt exception handling has started |
| rest_req | input | 1 | Request to restore the bank into the register file |
| rf_rd_idx | output | 4*5 | Four register slot indices being read |
| rf_rd_data | input | 4*DATA_W | Combinational read data for the four slots |
| rf_wr_en | output | 1 | Write strobe for four registers |
| rf_wr_idx | output | 4*5 | Four register slot indices being written |
| rf_wr_data | output | 4*DATA_W | Data written to the four slots |
| fetch_stall | output | 1 | Holds back the service routine's first fetch |
| busy | output | 1 | A save or restore is in progress |
| done | output | 1 | One-cycle pulse when a save or restore ends |
| bank_valid | output | 1 | The bank holds a save not yet restored |
| restore_err | output | 1 | One-cycle pulse for a restore with nothing saved |

## Verification
The assertions assume that reset is applied synchronously before any trigger. They also assume that the register file answers a read within the same cycle, because the capture takes `rf_rd_data` at the edge that ends each step. Triggers and requests are taken to be plain per-cycle samples, with no handshake implied. The stimulus changes inputs only on the falling clock edge and models the register file as a combinational array. It deliberately presents triggers during busy cycles and simultaneous trigger/request pairs, but never releases reset in the middle of a sequence.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
   localparam int unsigned LANES      = 4;
   localparam int unsigned GROUPS     = 5;
   localparam int unsigned RF_ENTRIES = LANES * GROUPS;
   localparam int unsigned IDX_W      = $clog2(RF_ENTRIES);
   localparam int unsigned GRP_W      = $clog2(GROUPS);

   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_SAVE = 2'd1,
      SEQ_REST = 2'd2
   } seq_state_e;
endpackage

// File: rtl/irq_bank_grp_map.sv
module irq_bank_grp_map
   import irq_bank_pkg::*;
(
   input  logic [GRP_W-1:0]       grp,
   output logic [LANES*IDX_W-1:0] idx_flat
);
   // Group 0 holds the special registers, top slot first. Later groups walk
   // down the general registers four at a time; slot 15 (MACH) falls into group 1.
   for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int unsigned SPECIAL_SLOT = RF_ENTRIES - 1 - l;
      logic [IDX_W-1:0] gen_slot;
      always_comb begin
         gen_slot = IDX_W'((GROUPS - 1 - int'(grp)) * LANES + l);
      end
      assign idx_flat[l*IDX_W +: IDX_W] = (grp == '0) ? IDX_W'(SPECIAL_SLOT) : gen_slot;
   end
endmodule

// File: rtl/irq_bank_ctrl.sv
module irq_bank_ctrl
   import irq_bank_pkg::*;
(
   input  logic             clk,
   input  logic             rst,
   input  logic             save_trig,
   input  logic             rest_req,
   output logic [GRP_W-1:0] step,
   output logic             saving,
   output logic             restoring,
   output logic             fetch_stall,
   output logic             busy,
   output logic             done,
   output logic             bank_valid,
   output logic             restore_err
);
   localparam logic [GRP_W-1:0] LAST_STEP = GRP_W'(GROUPS - 1);

   seq_state_e state_q;
   logic [GRP_W-1:0] step_q;
   logic valid_q, done_q, err_q;
   logic idle, last, start_save, start_rest, bad_rest;

   always_comb begin
      idle       = (state_q == SEQ_IDLE);
      last       = (step_q == LAST_STEP);
      start_save = idle && save_trig;
      start_rest = idle && !save_trig && rest_req && valid_q;
      bad_rest   = idle && !save_trig && rest_req && !valid_q;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= SEQ_IDLE;
         step_q  <= '0;
         valid_q <= 1'b0;
         done_q  <= 1'b0;
         err_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         err_q  <= bad_rest;
         unique case (state_q)
            SEQ_IDLE: begin
               step_q <= '0;
               if (start_save)      state_q <= SEQ_SAVE;
               else if (start_rest) state_q <= SEQ_REST;
            end
            SEQ_SAVE: begin
               if (last) begin
                  state_q <= SEQ_IDLE;
                  step_q  <= '0;
                  valid_q <= 1'b1;
                  done_q  <= 1'b1;
               end else begin
                  step_q <= step_q + 1'b1;
               end
            end
            SEQ_REST: begin
               if (last) begin
                  state_q <= SEQ_IDLE;
                  step_q  <= '0;
                  valid_q <= 1'b0;
                  done_q  <= 1'b1;
               end else begin
                  step_q <= step_q + 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign step        = step_q;
   assign saving      = (state_q == SEQ_SAVE);
   assign restoring   = (state_q == SEQ_REST);
   assign busy        = !idle;
   assign fetch_stall = start_save || saving;
   assign done        = done_q;
   assign bank_valid  = valid_q;
   assign restore_err = err_q;

   assert_step_range_R2: assert property (@(posedge clk) disable iff (rst)
      step_q <= LAST_STEP);
   assert_save_sets_valid_R4: assert property (@(posedge clk) disable iff (rst)
      (saving && last) |=> (bank_valid && done && !busy));
   assert_rest_clears_valid_R5: assert property (@(posedge clk) disable iff (rst)
      (restoring && last) |=> (!bank_valid && done));
   assert_err_single_R7: assert property (@(posedge clk) disable iff (rst)
      restore_err |=> !restore_err);
   assert_err_idle_R7: assert property (@(posedge clk) disable iff (rst)
      restore_err |-> !busy);
   assert_busy_ignores_R6: assert property (@(posedge clk) disable iff (rst)
      (saving && !last) |=> saving);
endmodule

// File: rtl/irq_bank_store.sv
module irq_bank_store
   import irq_bank_pkg::*;
#(
   parameter int unsigned DATA_W         = 32,
   parameter bit          CLEAR_ON_RESET = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      cap_en,
   input  logic [GRP_W-1:0]          grp,
   input  logic [LANES*DATA_W-1:0]   cap_data,
   output logic [LANES*DATA_W-1:0]   out_data
);
   localparam int unsigned ROW_W = LANES * DATA_W;

   logic [ROW_W-1:0] row_q [GROUPS];

   for (genvar g = 0; g < GROUPS; g++) begin : g_row
      logic hit;
      assign hit = cap_en && (grp == GRP_W'(g));
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk) begin
            if (rst)      row_q[g] <= '0;
            else if (hit) row_q[g] <= cap_data;
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (hit) row_q[g] <= cap_data;
         end
      end
   end

   always_comb begin
      out_data = '0;
      for (int g = 0; g < GROUPS; g++) begin
         if (grp == GRP_W'(g)) out_data = row_q[g];
      end
   end

   assert_cap_grp_R2: assert property (@(posedge clk) disable iff (rst)
      cap_en |-> (int'(grp) < GROUPS));
endmodule

// File: rtl/irq_bank_seq.sv
module irq_bank_seq
   import irq_bank_pkg::*;
#(
   parameter int unsigned DATA_W         = 32,
   parameter bit          CLEAR_ON_RESET = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst,
   input  logic                      save_trig,
   input  logic                      rest_req,
   output logic [LANES*IDX_W-1:0]    rf_rd_idx,
   input  logic [LANES*DATA_W-1:0]   rf_rd_data,
   output logic                      rf_wr_en,
   output logic [LANES*IDX_W-1:0]    rf_wr_idx,
   output logic [LANES*DATA_W-1:0]   rf_wr_data,
   output logic                      fetch_stall,
   output logic                      busy,
   output logic                      done,
   output logic                      bank_valid,
   output logic                      restore_err
);
   if (DATA_W < 1) begin : g_bad_width
      $error("irq_bank_seq: DATA_W must be at least 1");
   end
   if (RF_ENTRIES != 20 || LANES != 4) begin : g_bad_shape
      $error("irq_bank_seq: group map expects four lanes and twenty slots");
   end

   logic [GRP_W-1:0]       step;
   logic                   saving, restoring;
   logic [LANES*IDX_W-1:0] step_idx;

   irq_bank_ctrl u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .save_trig   (save_trig),
      .rest_req    (rest_req),
      .step        (step),
      .saving      (saving),
      .restoring   (restoring),
      .fetch_stall (fetch_stall),
      .busy        (busy),
      .done        (done),
      .bank_valid  (bank_valid),
      .restore_err (restore_err)
   );

   irq_bank_grp_map u_map (
      .grp      (step),
      .idx_flat (step_idx)
   );

   irq_bank_store #(
      .DATA_W         (DATA_W),
      .CLEAR_ON_RESET (CLEAR_ON_RESET)
   ) u_store (
      .clk      (clk),
      .rst      (rst),
      .cap_en   (saving),
      .grp      (step),
      .cap_data (rf_rd_data),
      .out_data (rf_wr_data)
   );

   assign rf_rd_idx = step_idx;
   assign rf_wr_idx = step_idx;
   assign rf_wr_en  = restoring;

   assert_wr_needs_busy_R5: assert property (@(posedge clk) disable iff (rst)
      rf_wr_en |-> (busy && !fetch_stall));
   assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);
   assert_stall_in_save_R3: assert property (@(posedge clk) disable iff (rst)
      (busy && !rf_wr_en) |-> fetch_stall);
   assert_no_write_on_err_R7: assert property (@(posedge clk) disable iff (rst)
      restore_err |-> !rf_wr_en);
endmodule

// File: tb/irq_bank_seq_tb_top.sv
`timescale 1ns/1ps
module irq_bank_seq_tb_top;
   localparam int DW = 32;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst, save_trig, rest_req;
   logic [19:0]     rf_rd_idx, rf_wr_idx;
   logic [4*DW-1:0] rf_rd_data, rf_wr_data;
   logic rf_wr_en, fetch_stall, busy, done, bank_valid, restore_err;

   irq_bank_seq #(.DATA_W(DW)) dut_i (
      .clk(clk), .rst(rst), .save_trig(save_trig), .rest_req(rest_req),
      .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
      .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
      .fetch_stall(fetch_stall), .busy(busy), .done(done),
      .bank_valid(bank_valid), .restore_err(restore_err)
   );

   logic [DW-1:0] rf [20];
   logic [DW-1:0] exp_img [20];
   int order [20] = '{19,18,17,16, 12,13,14,15, 8,9,10,11, 4,5,6,7, 0,1,2,3};
   int checks = 0, errors = 0;

   always_comb begin
      for (int l = 0; l < 4; l++) begin
         if (rf_rd_idx[l*5 +: 5] < 20) rf_rd_data[l*DW +: DW] = rf[rf_rd_idx[l*5 +: 5]];
         else                          rf_rd_data[l*DW +: DW] = '0;
      end
   end

   always @(posedge clk) begin
      if (rf_wr_en)
         for (int l = 0; l < 4; l++)
            if (rf_wr_idx[l*5 +: 5] < 20) rf[rf_wr_idx[l*5 +: 5]] <= rf_wr_data[l*DW +: DW];
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic fill_rf(input logic [DW-1:0] seed);
      for (int i = 0; i < 20; i++) rf[i] = seed + DW'(i) * 32'h0101_0101;
   endtask

   task automatic snap_rf();
      for (int i = 0; i < 20; i++) exp_img[i] = rf[i];
   endtask

   task automatic cmp_rf(input string req);
      for (int i = 0; i < 20; i++) chk(rf[i] == exp_img[i], req, 64'(rf[i]), 64'(exp_img[i]));
   endtask

   // Save; poke_step >= 0 pulses both inputs during that busy step (R6).
   task automatic run_save(input int poke_step, input bit with_rest, input string req);
      @(negedge clk);
      save_trig = 1'b1;
      rest_req  = with_rest;
      #0.5;
      chk(fetch_stall == 1'b1, "R3 stall in trigger cycle", 64'(fetch_stall), 64'd1);
      @(negedge clk);
      save_trig = 1'b0;
      rest_req  = 1'b0;
      for (int k = 0; k < 5; k++) begin
         chk(busy == 1'b1, "R4 busy during save", 64'(busy), 64'd1);
         chk(fetch_stall == 1'b1, "R3 stall during save", 64'(fetch_stall), 64'd1);
         chk(rf_wr_en == 1'b0, "R6/R8 no write during save", 64'(rf_wr_en), 64'd0);
         for (int l = 0; l < 4; l++)
            chk(int'(rf_rd_idx[l*5 +: 5]) == order[k*4+l], req,
                64'(rf_rd_idx[l*5 +: 5]), 64'(order[k*4+l]));
         if (k == poke_step) begin
            save_trig = 1'b1;
            rest_req  = 1'b1;
         end
         @(negedge clk);
         save_trig = 1'b0;
         rest_req  = 1'b0;
      end
      chk(busy == 1'b0, "R4 busy low after five", 64'(busy), 64'd0);
      chk(done == 1'b1, "R4 done pulse", 64'(done), 64'd1);
      chk(bank_valid == 1'b1, "R4/R9 valid after save", 64'(bank_valid), 64'd1);
      chk(fetch_stall == 1'b0, "R3 stall released", 64'(fetch_stall), 64'd0);
      @(negedge clk);
      chk(done == 1'b0, "R4 done one cycle", 64'(done), 64'd0);
      chk(busy == 1'b0 && rf_wr_en == 1'b0, "R6 no follow-on sequence", 64'(busy), 64'd0);
   endtask

   // Restore expecting exp_img; poke_step >= 0 pulses save_trig in that step (R6).
   task automatic run_restore(input int poke_step);
      @(negedge clk);
      rest_req = 1'b1;
      @(negedge clk);
      rest_req = 1'b0;
      for (int k = 0; k < 5; k++) begin
         chk(rf_wr_en == 1'b1, "R5 write strobe", 64'(rf_wr_en), 64'd1);
         chk(busy == 1'b1, "R5 busy during restore", 64'(busy), 64'd1);
         for (int l = 0; l < 4; l++) begin
            chk(int'(rf_wr_idx[l*5 +: 5]) == order[k*4+l], "R5 write order",
                64'(rf_wr_idx[l*5 +: 5]), 64'(order[k*4+l]));
            chk(rf_wr_data[l*DW +: DW] == exp_img[order[k*4+l]], "R5 write data",
                64'(rf_wr_data[l*DW +: DW]), 64'(exp_img[order[k*4+l]]));
         end
         if (k == poke_step) save_trig = 1'b1;
         @(negedge clk);
         save_trig = 1'b0;
      end
      chk(done == 1'b1, "R5 done pulse", 64'(done), 64'd1);
      chk(bank_valid == 1'b0, "R5/R6 valid cleared", 64'(bank_valid), 64'd0);
      chk(busy == 1'b0 && rf_wr_en == 1'b0, "R5 idle after restore", 64'(busy), 64'd0);
      @(negedge clk);
      chk(busy == 1'b0, "R6 no save after restore", 64'(busy), 64'd0);
      cmp_rf("R5 register file restored");
   endtask

   task automatic t_reset();
      rst = 1'b1; save_trig = 1'b0; rest_req = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk({busy, done, bank_valid, restore_err, fetch_stall, rf_wr_en} == 6'b0,
          "R1 reset state", 64'({busy, done, bank_valid, restore_err, fetch_stall, rf_wr_en}), 64'd0);
   endtask

   task automatic t_save_restore();
      fill_rf(32'h1000_0000);
      snap_rf();
      run_save(-1, 1'b0, "R2 read order");
      fill_rf(32'hA5A5_0000);
      run_restore(-1);
   endtask

   task automatic t_bad_restore();
      snap_rf();
      @(negedge clk);
      rest_req = 1'b1;
      @(negedge clk);
      rest_req = 1'b0;
      chk(restore_err == 1'b1, "R7 error pulse", 64'(restore_err), 64'd1);
      chk(busy == 1'b0, "R7 not busy", 64'(busy), 64'd0);
      for (int k = 0; k < 6; k++) begin
         @(negedge clk);
         chk(restore_err == 1'b0, "R7 error one cycle", 64'(restore_err), 64'd0);
         chk(rf_wr_en == 1'b0, "R7 no write", 64'(rf_wr_en), 64'd0);
      end
      cmp_rf("R7 registers unchanged");
   endtask

   task automatic t_busy_ignore();
      fill_rf(32'h2200_0000);
      snap_rf();
      run_save(2, 1'b0, "R6 order kept under poke");
      fill_rf(32'h7700_0000);
      run_restore(1);
   endtask

   task automatic t_collide_overwrite();
      fill_rf(32'h3300_0000);
      run_save(-1, 1'b0, "R2 first save");
      fill_rf(32'h4400_0000);
      snap_rf();
      run_save(-1, 1'b1, "R8 save wins");
      fill_rf(32'h5500_0000);
      run_restore(-1);
   endtask

   bit finished = 1'b0;

   initial begin
      t_reset();
      t_save_restore();
      t_bad_restore();
      t_busy_ignore();
      t_collide_overwrite();
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule